// File: doc/BRIEF.md
# Load-Store Alignment Guard

This block sits between the address-generation stage of a load-store unit and the memory request path. Every cycle with a valid request it decides one of three outcomes:

- **Pass aligned.** The request passes downstream as an aligned access.
- **Pass misaligned.** The request passes downstream flagged as misaligned, so the memory side can break it into several bus beats.
- **Fault.** The request is refused and an alignment fault is raised toward the exception logic.

The decision uses the access size, the instruction class and the low address bits. It also uses the memory type of the target region, which arrives from an external region lookup, and a global control bit that permits unaligned single accesses.

Signed byte and halfword loads share the size encodings of their unsigned forms, so they need no separate input. The accept and misaligned outputs are combinational, so an allowed request costs no extra cycle. A refused request is never forwarded. One cycle later a registered fault pulse appears together with the address that caused it.

Top module: `align_guard`

## Requirements
- R1: A single-class byte access (size code 0) is accepted with the misaligned flag low for any address, memory type and enable setting.
- R2: A single-class access needs natural alignment. Size code 1 is 2 bytes, code 2 is 4 bytes and code 3 is 8 bytes, and the access is misaligned when the address modulo the size is nonzero. An aligned valid request is accepted in the same cycle with the misaligned flag low.
- R3: Class codes 1 (multi-register), 2 (doubleword pair) and 3 (reserved, treated the same way) need address bits [1:0] to be zero, whatever the size code. If those bits are not zero the request faults, even when the unaligned enable is set and the region is Normal. A pair at an address that is 4-aligned but not 8-aligned is accepted as aligned.
- R4: A misaligned single-class access faults when the unaligned enable input is 0.
- R5: A misaligned single-class access to a Device region (device input 1) faults whatever the enable setting.
- R6: A misaligned single-class access with the enable at 1 to a Normal region (device input 0) is accepted in the same cycle with the misaligned flag high.
- R7: When a valid request faults, the accept output is low in that cycle. The fault output is high in the next cycle only, and the fault address output equals the request address. Back-to-back faulting requests give one high cycle each, each with its own address.
- R8: After reset the fault output is low and the fault address is zero. With the valid input low, accept and misaligned stay low and no fault follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_size_i | input | 2 | Size code: 0 byte, 1 half, 2 word, 3 doubleword |
| req_class_i | input | 2 | Class code: 0 single, 1 multi-register, 2 pair, 3 reserved |
| req_addr_i | input | ADDR_W | Byte address of the request |
| req_device_i | input | 1 | Target region is Device memory (1) or Normal (0) |
| unaligned_en_i | input | 1 | Global permission for unaligned single accesses |
| req_accept_o | output | 1 | Request forwarded downstream (combinational) |
| req_misaligned_o | output | 1 | Forwarded request is misaligned (combinational) |
| fault_o | output | 1 | Alignment fault, one cycle after the faulting request |
| fault_addr_o | output | ADDR_W | Address of the faulting request |

## Verification
Accept and misaligned are due in the same cycle as the request. The bench drives each request on a falling edge and samples these two outputs a moment later, before any rising edge. The fault pulse and its address are due one cycle after the request. The bench samples them on the next falling edge, after the register has updated, and then again one edge later to confirm that the pulse has ended. For back-to-back faults the bench issues the second request on that same falling edge and checks the first fault address while the second request is still being driven.

// File: rtl/align_pkg.sv
package align_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DWRD = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    CL_SINGLE = 2'd0,
    CL_MULTI  = 2'd1,
    CL_PAIR   = 2'd2,
    CL_RSVD   = 2'd3
  } class_e;
endpackage

// File: rtl/align_need.sv
// Computes which low address bits must be zero and tests them.
module align_need #(
  parameter int OFF_W     = 3,
  parameter int STRICT_LG = 2
) (
  input  logic [1:0]       size_i,
  input  logic [1:0]       cls_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             mis_o,
  output logic             strict_o
);
  import align_pkg::*;
  localparam int LG_W = $clog2(OFF_W + 1);

  logic [LG_W-1:0]  need_lg;
  logic [OFF_W-1:0] mask;

  assign strict_o = (cls_i != CL_SINGLE);
  assign need_lg  = strict_o ? LG_W'(STRICT_LG) : LG_W'(size_i);

  for (genvar i = 0; i < OFF_W; i++) begin : g_mask
    assign mask[i] = (LG_W'(i) < need_lg);
  end

  assign mis_o = |(off_i & mask);
endmodule

// File: rtl/align_policy.sv
// Decides forward, forward-misaligned, or fault.
module align_policy (
  input  logic valid_i,
  input  logic mis_i,
  input  logic strict_i,
  input  logic en_i,
  input  logic dev_i,
  output logic accept_o,
  output logic mis_o,
  output logic fault_req_o
);
  logic allow_unal;
  logic refuse;

  assign allow_unal  = !strict_i && en_i && !dev_i;
  assign refuse      = mis_i && !allow_unal;
  assign accept_o    = valid_i && !refuse;
  assign mis_o       = valid_i && mis_i && !refuse;
  assign fault_req_o = valid_i && refuse;
endmodule

// File: rtl/align_fault_reg.sv
module align_fault_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fault_req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              fault_o,
  output logic [ADDR_W-1:0] fault_addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_o      <= 1'b0;
      fault_addr_o <= '0;
    end else begin
      fault_o <= fault_req_i;
      if (fault_req_i) fault_addr_o <= addr_i;
    end
  end

  p_fault_follows_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_req_i |=> fault_o && (fault_addr_o == $past(addr_i)));
  p_fault_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_req_i |=> !fault_o);
endmodule

// File: rtl/align_guard.sv
module align_guard #(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 3,
  parameter int STRICT_LG = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_size_i,
  input  logic [1:0]        req_class_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_device_i,
  input  logic              unaligned_en_i,
  output logic              req_accept_o,
  output logic              req_misaligned_o,
  output logic              fault_o,
  output logic [ADDR_W-1:0] fault_addr_o
);
  logic mis, strict, fault_req;

  align_need #(.OFF_W(OFF_W), .STRICT_LG(STRICT_LG)) u_need (
    .size_i   (req_size_i),
    .cls_i    (req_class_i),
    .off_i    (req_addr_i[OFF_W-1:0]),
    .mis_o    (mis),
    .strict_o (strict)
  );

  align_policy u_policy (
    .valid_i     (req_valid_i),
    .mis_i       (mis),
    .strict_i    (strict),
    .en_i        (unaligned_en_i),
    .dev_i       (req_device_i),
    .accept_o    (req_accept_o),
    .mis_o       (req_misaligned_o),
    .fault_req_o (fault_req)
  );

  align_fault_reg #(.ADDR_W(ADDR_W)) u_fault (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fault_req_i  (fault_req),
    .addr_i       (req_addr_i),
    .fault_o      (fault_o),
    .fault_addr_o (fault_addr_o)
  );

  p_byte_ok_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_size_i == 2'd0 && req_class_i == 2'd0
      |-> req_accept_o && !req_misaligned_o);
  p_strict_word_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_accept_o && req_class_i != 2'd0 |-> req_addr_i[1:0] == 2'b00 && !req_misaligned_o);
  p_need_enable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_accept_o && !unaligned_en_i |-> !req_misaligned_o);
  p_device_aligned_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_accept_o && req_device_i |-> !req_misaligned_o);
  p_mis_only_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_misaligned_o |-> req_accept_o && req_class_i == 2'd0);
  p_refused_faults_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_accept_o |=> fault_o && fault_addr_o == $past(req_addr_i));
  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !req_accept_o && !req_misaligned_o ##1 !fault_o);
endmodule

// File: tb/sim_align_guard.sv
module sim_align_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  size = '0;
  logic [1:0]  cls = '0;
  logic [31:0] addr = '0;
  logic        dev = 1'b0;
  logic        en = 1'b0;
  logic        acc, mis, flt;
  logic [31:0] faddr;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  align_guard u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_size_i(size),
    .req_class_i(cls), .req_addr_i(addr), .req_device_i(dev),
    .unaligned_en_i(en), .req_accept_o(acc), .req_misaligned_o(mis),
    .fault_o(flt), .fault_addr_o(faddr)
  );

  typedef struct packed {
    logic [1:0]  c;
    logic [1:0]  s;
    logic        d;
    logic        e;
    logic [31:0] a;
    logic        xa;
    logic        xm;
    logic        xf;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TAB [NV] = '{
    '{2'd0, 2'd0, 1'b1, 1'b0, 32'h0000_1003, 1'b1, 1'b0, 1'b0}, // R1
    '{2'd0, 2'd1, 1'b0, 1'b0, 32'h0000_1002, 1'b1, 1'b0, 1'b0}, // R2
    '{2'd0, 2'd1, 1'b0, 1'b0, 32'h0000_1001, 1'b0, 1'b0, 1'b1}, // R4
    '{2'd0, 2'd2, 1'b0, 1'b1, 32'h0000_2006, 1'b1, 1'b1, 1'b0}, // R6
    '{2'd0, 2'd2, 1'b1, 1'b1, 32'h0000_2006, 1'b0, 1'b0, 1'b1}, // R5
    '{2'd0, 2'd3, 1'b0, 1'b0, 32'h0000_3008, 1'b1, 1'b0, 1'b0}, // R2
    '{2'd0, 2'd3, 1'b0, 1'b0, 32'h0000_3004, 1'b0, 1'b0, 1'b1}, // R2
    '{2'd0, 2'd3, 1'b0, 1'b1, 32'h0000_300C, 1'b1, 1'b1, 1'b0}, // R6
    '{2'd1, 2'd2, 1'b0, 1'b1, 32'h0000_4004, 1'b1, 1'b0, 1'b0}, // R3
    '{2'd1, 2'd2, 1'b0, 1'b1, 32'h0000_4002, 1'b0, 1'b0, 1'b1}, // R3
    '{2'd2, 2'd3, 1'b0, 1'b1, 32'h0000_5004, 1'b1, 1'b0, 1'b0}, // R3
    '{2'd2, 2'd3, 1'b0, 1'b1, 32'h0000_5001, 1'b0, 1'b0, 1'b1}, // R3
    '{2'd3, 2'd2, 1'b0, 1'b1, 32'h0000_6002, 1'b0, 1'b0, 1'b1}, // R3
    '{2'd1, 2'd0, 1'b0, 1'b1, 32'h0000_7001, 1'b0, 1'b0, 1'b1}, // R3
    '{2'd0, 2'd2, 1'b1, 1'b0, 32'h0000_8005, 1'b0, 1'b0, 1'b1}, // R5
    '{2'd0, 2'd1, 1'b0, 1'b1, 32'hFFFF_FFFB, 1'b1, 1'b1, 1'b0}  // R6
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] c, input logic [1:0] s, input logic d,
                       input logic e, input logic [31:0] a);
    valid = 1'b1; cls = c; size = s; dev = d; en = e; addr = a;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 reset fault", 32'(flt), 32'd0);
    chk("R8 reset addr", faddr, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(TAB[i].c, TAB[i].s, TAB[i].d, TAB[i].e, TAB[i].a);
      #1;
      chk($sformatf("vec%0d accept", i), 32'(acc), 32'(TAB[i].xa));
      chk($sformatf("vec%0d misaligned", i), 32'(mis), 32'(TAB[i].xm));
      @(negedge clk);
      valid = 1'b0;
      chk($sformatf("vec%0d fault R7", i), 32'(flt), 32'(TAB[i].xf));
      if (TAB[i].xf) chk($sformatf("vec%0d fault addr R7", i), faddr, TAB[i].a);
      @(negedge clk);
      chk($sformatf("vec%0d pulse end R7", i), 32'(flt), 32'd0);
    end

    // R8: idle with misaligned inputs present
    valid = 1'b0; cls = 2'd1; size = 2'd2; addr = 32'h0000_0003; en = 1'b0;
    #1;
    chk("R8 idle accept", 32'(acc), 32'd0);
    chk("R8 idle misaligned", 32'(mis), 32'd0);
    @(negedge clk);
    chk("R8 idle no fault", 32'(flt), 32'd0);

    // R7: back-to-back faults
    drive(2'd0, 2'd2, 1'b0, 1'b0, 32'h0000_A001);
    #1 chk("R7 b2b first accept", 32'(acc), 32'd0);
    @(negedge clk);
    drive(2'd2, 2'd3, 1'b0, 1'b1, 32'h0000_B002);
    chk("R7 b2b first fault", 32'(flt), 32'd1);
    chk("R7 b2b first addr", faddr, 32'h0000_A001);
    @(negedge clk);
    valid = 1'b0;
    chk("R7 b2b second fault", 32'(flt), 32'd1);
    chk("R7 b2b second addr", faddr, 32'h0000_B002);
    @(negedge clk);
    chk("R7 b2b end", 32'(flt), 32'd0);
    chk("R7 addr held", faddr, 32'h0000_B002);

    // R1: byte at every offset with strict settings
    for (int k = 0; k < 8; k++) begin
      drive(2'd0, 2'd0, 1'b1, 1'b0, 32'h0000_C000 + 32'(k));
      #1 chk($sformatf("R1 byte off%0d", k), {30'd0, acc, mis}, 32'd2);
      @(negedge clk);
    end
    valid = 1'b0;
    @(negedge clk);
    chk("R1 no fault", 32'(flt), 32'd0);

    // R8: reset mid-run clears fault
    drive(2'd1, 2'd2, 1'b0, 1'b1, 32'h0000_D003);
    @(negedge clk);
    valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R8 async reset fault", 32'(flt), 32'd0);
    chk("R8 async reset addr", faddr, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule